// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Bypass

This block sits between up to 32 level-sensitive interrupt sources and a parent interrupt controller. It folds the sources into a small number of parent lines. Each aggregated parent line has its own group of sources, chosen by an elaboration-time map mask, and the groups do not overlap. A source joins a group only while software has set its enable bit. Bit positions that no map mask names are treated as unwired and never reach any output.

The lowest few sources, typically serial-port interrupts, each have a bypass path to a dedicated parent line. When the forward mask selects such a source, its raw level goes straight to that line with no synchronizer and no register, and no enable gates it. The aggregation logic ignores that source completely. When the forward bit is clear, the dedicated line stays low and the source is aggregated like any other mapped input.

An 8-byte register window gives software two 32-bit words. One is a read/write enable mask. The other is a read-only view of the synchronized, live sources. A wake output tells the system, during suspend, that an enabled source is pending, provided wake is enabled.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it falls, every aggregated output, the wake output and the read data are 0. The enable word resets to 0.
- R2: A write to byte offset 0x0 loads the enable word on the next rising edge. A read of offset 0x0 returns that word on `rd_data_o` one clock after `rd_en_i` is sampled, and `rd_data_o` holds its value until the next read.
- R3: A read of offset 0x4 returns the synchronized sources ANDed with the live mask. The live mask is the union of the map masks with the forwarded bits cleared, so 0x00000FF8 by default. Writes to offset 0x4 change nothing.
- R4: Aggregated output k is high when any source i is high with enable bit i set, map mask k bit i set and i not forwarded. A source change appears on the output on the third rising edge after it is applied: two synchronizer stages, then one output register.
- R5: A source at an unwired position (12 to 31 by default) never raises an aggregated output, the wake output or a status bit, even when its enable bit is set.
- R6: For each line j below N_FWD whose forward bit is set, `fwd_irq_o[j]` follows `irq_i[j]` combinationally, whatever the enable word holds. That source never affects the aggregated outputs, the status word or the wake output.
- R7: For each line j below N_FWD whose forward bit is clear, `fwd_irq_o[j]` stays 0. Source j is then aggregated through the map masks.
- R8: The wake output is registered and has the same latency as R4. It is high only when `wake_en_i` was high at the sampling edge and at least one enabled, live source was pending.
- R9: With the default maps, input 3 raises aggregated output 0 only and input 6 raises aggregated output 1 only. These are the masks 0xEB8 and 0x140.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | SRC_W | Level-sensitive interrupt sources |
| wake_en_i | input | 1 | Allows the wake output to assert |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset in the register window |
| wr_data_i | input | SRC_W | Register write data |
| rd_data_o | output | SRC_W | Registered read data |
| agg_irq_o | output | N_AGG | Aggregated parent interrupt lines |
| fwd_irq_o | output | N_FWD | Dedicated bypass parent lines |
| wake_o | output | 1 | Registered wake request |

## Verification
A source change made at a falling edge reaches the aggregated and wake outputs on the third rising edge that follows. The bench therefore waits three full clocks before its directed checks. Enable writes take effect one edge earlier than the output register, and read data appears on the edge that samples the strobe. The bypass lines have no register, so they are checked one nanosecond after the source moves. A behavioural model steps the same pipeline depth with plain variables and compares the registered outputs at every falling edge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int OFS_ENABLE = 0;
  localparam int OFS_STATUS = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_cascade_pkg::*;
#(
  parameter int              W      = 32,
  parameter int              ADDR_W = 3,
  parameter logic [W-1:0]    LIVE   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      sync_in,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      rd_data
);
  reg_sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else                                  sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && sel == SEL_ENABLE) en_q <= wr_data;
      if (rd_en) begin
        case (sel)
          SEL_ENABLE: rd_data <= en_q;
          SEL_STATUS: rd_data <= sync_in & LIVE;
          default:    rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int                   W     = 32,
  parameter int                   N_OUT = 2,
  parameter logic [N_OUT*W-1:0]   MAPS  = '0,
  parameter logic [W-1:0]         LIVE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     en,
  input  logic             wake_en,
  output logic [N_OUT-1:0] agg_q,
  output logic             wake_q
);
  logic [W-1:0]     armed;
  logic [N_OUT-1:0] agg_d;

  assign armed = src & en & LIVE;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign agg_d[k] = |(armed & MAPS[k*W +: W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agg_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      agg_q  <= agg_d;
      wake_q <= wake_en & (|armed);
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int                       SRC_W     = 32,
  parameter int                       N_AGG     = 2,
  parameter int                       N_FWD     = 3,
  parameter int                       ADDR_W    = 3,
  parameter logic [N_AGG*SRC_W-1:0]   MAP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [SRC_W-1:0]         FWD_MASK  = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  irq_i,
  input  logic              wake_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_W-1:0]  wr_data_i,
  output logic [SRC_W-1:0]  rd_data_o,
  output logic [N_AGG-1:0]  agg_irq_o,
  output logic [N_FWD-1:0]  fwd_irq_o,
  output logic              wake_o
);
  function automatic logic [SRC_W-1:0] union_maps();
    logic [SRC_W-1:0] u;
    u = '0;
    for (int k = 0; k < N_AGG; k++) u |= MAP_MASKS[k*SRC_W +: SRC_W];
    return u;
  endfunction

  function automatic logic [SRC_W-1:0] low_ones(int n);
    logic [SRC_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [SRC_W-1:0] FWD_EFF = FWD_MASK & low_ones(N_FWD);
  localparam logic [SRC_W-1:0] WIRED   = union_maps();
  localparam logic [SRC_W-1:0] LIVE    = WIRED & ~FWD_EFF;

  logic [SRC_W-1:0] irq_s;
  logic [SRC_W-1:0] en_q;

  for (genvar j = 0; j < N_FWD; j++) begin : g_fwd
    if (FWD_EFF[j]) begin : g_pass
      assign fwd_irq_o[j] = irq_i[j];
    end else begin : g_tie
      assign fwd_irq_o[j] = 1'b0;
    end
  end

  irq_sync #(.W(SRC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_i),
    .q   (irq_s)
  );

  irq_regs #(.W(SRC_W), .ADDR_W(ADDR_W), .LIVE(LIVE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .rd_en   (rd_en_i),
    .addr    (addr_i),
    .wr_data (wr_data_i),
    .sync_in (irq_s),
    .en_q    (en_q),
    .rd_data (rd_data_o)
  );

  irq_agg #(.W(SRC_W), .N_OUT(N_AGG), .MAPS(MAP_MASKS), .LIVE(LIVE)) u_agg (
    .clk     (clk),
    .rst     (rst),
    .src     (irq_s),
    .en      (en_q),
    .wake_en (wake_en_i),
    .agg_q   (agg_irq_o),
    .wake_q  (wake_o)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int                       SRC_W     = 32,
  parameter int                       N_AGG     = 2,
  parameter int                       N_FWD     = 3,
  parameter int                       ADDR_W    = 3,
  parameter logic [N_AGG*SRC_W-1:0]   MAP_MASKS = '0,
  parameter logic [SRC_W-1:0]         FWD_MASK  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [N_FWD-1:0]  irq_lo,
  input logic              wake_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SRC_W-1:0]  rd_data_o,
  input logic [N_AGG-1:0]  agg_irq_o,
  input logic [N_FWD-1:0]  fwd_irq_o,
  input logic              wake_o,
  input logic [SRC_W-1:0]  irq_s,
  input logic [SRC_W-1:0]  en_q
);
  function automatic logic [SRC_W-1:0] live_bits();
    logic [SRC_W-1:0] u;
    u = '0;
    for (int k = 0; k < N_AGG; k++) u |= MAP_MASKS[k*SRC_W +: SRC_W];
    for (int j = 0; j < N_FWD; j++) if (FWD_MASK[j]) u[j] = 1'b0;
    return u;
  endfunction

  localparam logic [SRC_W-1:0] LIVE_C = live_bits();

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (agg_irq_o == '0 && !wake_o && rd_data_o == '0));

  // R3
  status_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_i && addr_i == ADDR_W'(4)) |-> ((rd_data_o & ~LIVE_C) == '0));

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(wake_en_i));

  for (genvar k = 0; k < N_AGG; k++) begin : g_agg_chk
    // R4
    agg_source_chk: assert property (@(posedge clk) disable iff (rst)
      agg_irq_o[k] |-> $past(|(irq_s & en_q & LIVE_C & MAP_MASKS[k*SRC_W +: SRC_W])));
  end

  for (genvar j = 0; j < N_FWD; j++) begin : g_fwd_chk
    always_comb begin
      // R6 R7
      fwd_path_chk: assert (fwd_irq_o[j] == (FWD_MASK[j] & irq_lo[j]));
    end
  end
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
  .SRC_W(SRC_W), .N_AGG(N_AGG), .N_FWD(N_FWD), .ADDR_W(ADDR_W),
  .MAP_MASKS(MAP_MASKS), .FWD_MASK(FWD_MASK)
) u_chk (
  .clk(clk), .rst(rst), .irq_lo(irq_i[N_FWD-1:0]), .wake_en_i(wake_en_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .rd_data_o(rd_data_o),
  .agg_irq_o(agg_irq_o), .fwd_irq_o(fwd_irq_o), .wake_o(wake_o),
  .irq_s(irq_s), .en_q(en_q)
);

// File: tb/irq_cascade_ctrl_test.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_test;
  localparam logic [31:0] M0  = 32'h0000_0EB8;
  localparam logic [31:0] M1  = 32'h0000_0140;
  localparam logic [31:0] F   = 32'h0000_0007;
  localparam logic [31:0] M0B = 32'h0000_0EBF;
  localparam logic [31:0] FB  = 32'h0000_0005;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic        wake_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data, rd_data2;
  logic [1:0]  agg, agg2;
  logic [2:0]  fwd, fwd2;
  logic        wake, wake2;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl uut (
    .clk(clk), .rst(rst), .irq_i(irq), .wake_en_i(wake_en), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data),
    .agg_irq_o(agg), .fwd_irq_o(fwd), .wake_o(wake));

  irq_cascade_ctrl #(.MAP_MASKS({M1, M0B}), .FWD_MASK(FB)) uut2 (
    .clk(clk), .rst(rst), .irq_i(irq), .wake_en_i(wake_en), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data2),
    .agg_irq_o(agg2), .fwd_irq_o(fwd2), .wake_o(wake2));

  // behavioural reference, stepped on every rising edge
  logic [31:0] hist[$];
  logic [31:0] m_en = '0, m_rd = '0;
  logic [1:0]  m_agg = '0, m_agg2 = '0;
  logic        m_wake = 1'b0;

  function automatic logic [31:0] live_of(logic [31:0] a, logic [31:0] b, logic [31:0] f);
    return (a | b) & ~f;
  endfunction

  always @(posedge clk) begin
    logic [31:0] seen;
    if (rst) begin
      hist = '{32'h0, 32'h0};
      m_en = '0; m_rd = '0; m_agg = '0; m_agg2 = '0; m_wake = 1'b0;
    end else begin
      seen = hist[0];
      if (rd_en) m_rd = (addr == 3'd0) ? m_en :
                        (addr == 3'd4) ? (seen & live_of(M0, M1, F)) : 32'h0;
      m_agg[0]  = |(seen & m_en & M0 & ~F);
      m_agg[1]  = |(seen & m_en & M1 & ~F);
      m_agg2[0] = |(seen & m_en & M0B & ~FB);
      m_agg2[1] = |(seen & m_en & M1 & ~FB);
      m_wake    = wake_en && |(seen & m_en & live_of(M0, M1, F));
      if (wr_en && addr == 3'd0) m_en = wdata;
      void'(hist.pop_front());
      hist.push_back(irq);
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(agg == m_agg, "R4 model agg", 32'(agg), 32'(m_agg));
      check(agg2 == m_agg2, "R7 model agg2", 32'(agg2), 32'(m_agg2));
      check(wake == m_wake, "R8 model wake", 32'(wake), 32'(m_wake));
      check(rd_data == m_rd, "R2 model rd_data", rd_data, m_rd);
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_irq(logic [31:0] v);
    @(negedge clk);
    irq = v;
    ticks(3);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    ticks(4);
    check(agg == 0 && !wake && rd_data == 0, "R1 during reset", {rd_data[29:0], agg}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(agg == 0 && !wake && rd_data == 0, "R1 after reset", {rd_data[29:0], agg}, 0);
    reg_read(3'd0, r);
    check(r == 0, "R1 enable reset", r, 0);

    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, r);
    check(r == 32'hFFFF_FFFF, "R2 enable readback", r, 32'hFFFF_FFFF);
    reg_write(3'd4, 32'h0);
    reg_read(3'd0, r);
    check(r == 32'hFFFF_FFFF, "R3 status write ignored", r, 32'hFFFF_FFFF);

    wake_en = 1'b1;
    @(negedge clk); irq = 32'h8;
    ticks(2);
    check(agg == 2'b00, "R4 not before third edge", 32'(agg), 0);
    ticks(1);
    check(agg == 2'b01, "R9 input3 to out0", 32'(agg), 1);
    check(wake == 1'b1, "R8 wake pending", 32'(wake), 1);
    reg_read(3'd4, r);
    check(r == 32'h8, "R3 status input3", r, 32'h8);

    set_irq(32'h40);
    check(agg == 2'b10, "R9 input6 to out1", 32'(agg), 2);

    set_irq(32'hFFFF_F000);
    check(agg == 2'b00 && !wake, "R5 unwired silent", {31'(agg), wake}, 0);
    reg_read(3'd4, r);
    check(r == 32'h0, "R5 unwired status", r, 0);

    @(negedge clk); irq = 32'h7; #1;
    check(fwd == 3'b111, "R6 forward passthrough", 32'(fwd), 7);
    check(fwd2 == 3'b101, "R7 fwd2 line1 held low", 32'(fwd2), 5);
    ticks(3);
    check(agg == 2'b00 && !wake, "R6 forwarded not aggregated", {31'(agg), wake}, 0);
    check(agg2 == 2'b01, "R7 line1 aggregated", 32'(agg2), 1);
    reg_read(3'd4, r);
    check(r == 32'h0, "R6 forwarded status clear", r, 0);

    reg_write(3'd0, 32'h8);
    @(negedge clk); irq = 32'h2; #1;
    check(fwd == 3'b010, "R6 forward ignores enable", 32'(fwd), 2);
    set_irq(32'h10);
    check(agg == 2'b00, "R4 disabled input gated", 32'(agg), 0);
    reg_read(3'd4, r);
    check(r == 32'h10, "R3 status ignores enable", r, 32'h10);

    set_irq(32'h8);
    check(agg == 2'b01 && wake, "R8 wake with enabled input", {31'(agg), wake}, 3);
    @(negedge clk); wake_en = 1'b0;
    @(negedge clk);
    check(!wake && agg == 2'b01, "R8 wake gated off", {31'(agg), wake}, 2);

    @(negedge clk); irq = 32'h0;
    ticks(3);
    check(agg == 2'b00, "R4 release", 32'(agg), 0);
    ticks(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule